// File: doc/BRIEF.md
# Bus Grant and Wait-Cycle Sequencer

This sequencer sits inside a small DSP core. It decides, cycle by cycle, when the core hands its data-memory bus to an external master and when extra wait cycles follow a wait instruction. An external master raises a request, and the sequencer answers with a grant. The grant is held back by one cycle when the request first lands in the opening cycle of a two-cycle instruction. While the grant is up, a stall output freezes the core pipeline. The first clock edge after the grant rises is the edge the external master uses to launch its access.

A wait instruction presents a mask together with a one-cycle strobe. The wait condition is the OR-reduction of the mask ANDed with the wait input. When the condition holds, wait cycles are appended. These wait cycles also carry the grant, so an external master can use them as access slots. A wait-out flag marks the instruction cycle and every wait cycle. A synchronous restart drives the grant directly, while an asynchronous reset keeps every output low.

Top module: `bus_wait_seq`

## Requirements
- R1: While `rst_n` is low, `bus_gnt`, `stall` and `wait_out` are all 0, whatever the other inputs do, including `restart`.
- R2: If a clock edge samples `bus_req`=1 with `two_cyc_first`=0 and `restart`=0, then `bus_gnt` and `stall` are 1 in the cycle that follows that edge.
- R3: If the first edge that sees `bus_req`=1 also sees `two_cyc_first`=1, the grant does not rise after that edge. It rises one edge later if the request is still present.
- R4: Once granted, `bus_gnt` and `stall` stay 1 for as long as `bus_req` stays 1. After the edge that samples `bus_req`=0, both return to 0 unless a wait cycle or restart holds the grant.
- R5: `wait_out` is 1 in the cycle where `wai_go` is 1, combinationally, and is 0 in idle cycles before any wait instruction.
- R6: The wait condition is true when any bit of `wait_in & wai_mask` is 1. If it is true at the edge that closes the `wai_go` cycle, a wait cycle follows in which `bus_gnt`, `stall` and `wait_out` are all 1.
- R7: At each edge that closes a wait cycle, the condition is re-evaluated against the mask captured with `wai_go`, ignoring the current `wai_mask`. Another wait cycle follows while it is true, and all three outputs drop once it is false.
- R8: If the condition is false when `wai_go` is sampled, no wait cycle follows. `wait_out` is 1 for that one cycle only, and `bus_gnt` stays 0.
- R9: `bus_gnt` equals 1 in every cycle with `restart`=1 and `rst_n`=1, and follows `restart` without a clock. An edge that samples `restart`=1 clears any pending grant and any wait cycle, so once restart falls all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, active on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| restart | input | 1 | Synchronous restart, active high |
| bus_req | input | 1 | External master asks for the data bus |
| two_cyc_first | input | 1 | Core is in the first cycle of a two-cycle instruction |
| wai_go | input | 1 | Wait instruction executes in this cycle |
| wai_mask | input | WAIT_W | Mask argument of the wait instruction |
| wait_in | input | WAIT_W | Wait condition inputs |
| bus_gnt | output | 1 | Data bus granted to the external master |
| wait_out | output | 1 | Wait instruction or wait cycle in progress |
| stall | output | 1 | Holds the core pipeline |

## Verification
The assertions assume three things about the inputs. First, `wai_go` is never raised while `stall` is 1, because a frozen core issues no instruction. Second, `two_cyc_first` is high only in the single opening cycle of an instruction. Third, `restart` is applied only with `rst_n` high. The stimulus drives inputs on the falling edge and presents each wait strobe only from an idle or granted-free cycle. It raises `two_cyc_first` for one cycle at a time. Restart is applied only after reset has been released.

// File: rtl/bus_wait_seq.sv
module bus_wait_seq #(
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              restart,
  input  logic              bus_req,
  input  logic              two_cyc_first,
  input  logic              wai_go,
  input  logic [WAIT_W-1:0] wai_mask,
  input  logic [WAIT_W-1:0] wait_in,
  output logic              bus_gnt,
  output logic              wait_out,
  output logic              stall
);

  logic              gnt_req_q;
  logic              wcyc_q;
  logic [WAIT_W-1:0] mask_q;
  logic              cond_new;
  logic              cond_held;

  assign cond_new  = |(wait_in & wai_mask);
  assign cond_held = |(wait_in & mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gnt_req_q <= 1'b0;
      wcyc_q    <= 1'b0;
      mask_q    <= '0;
    end else if (restart) begin
      gnt_req_q <= 1'b0;
      wcyc_q    <= 1'b0;
      mask_q    <= '0;
    end else begin
      gnt_req_q <= bus_req && (gnt_req_q || !two_cyc_first);
      if (wai_go) begin
        mask_q <= wai_mask;
        wcyc_q <= cond_new;
      end else if (wcyc_q) begin
        wcyc_q <= cond_held;
      end
    end
  end

  assign bus_gnt  = rst_n & (restart | gnt_req_q | wcyc_q);
  assign stall    = rst_n & (gnt_req_q | wcyc_q);
  assign wait_out = rst_n & (wai_go | wcyc_q);

  always_comb begin
    if (rst_n === 1'b0)
      assert_quiet_in_reset_R1: assert (!bus_gnt && !stall && !wait_out);
  end

  assert_grant_after_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !two_cyc_first && !restart) |=> (bus_gnt && stall));

  assert_grant_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && two_cyc_first && !gnt_req_q && !restart) |=> !gnt_req_q);

  assert_grant_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && gnt_req_q && !restart) |=> (bus_gnt && stall));

  assert_stall_implies_gnt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> bus_gnt);

  assert_flag_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wai_go |-> wait_out);

  assert_wait_entry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wai_go && cond_new && !restart) |=> (wait_out && bus_gnt && stall));

  assert_wait_repeat_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcyc_q && !wai_go && cond_held && !restart) |=> (wait_out && bus_gnt && stall));

  assert_wait_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wcyc_q && !wai_go && !cond_held) |=> !wcyc_q);

  assert_no_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wai_go && !cond_new) |=> !wcyc_q);

  assert_restart_gnt_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |-> bus_gnt);

  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!wcyc_q && !gnt_req_q));

endmodule

// File: tb/tb_bus_wait_seq.sv
module tb_bus_wait_seq;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n, restart, bus_req, two_cyc_first, wai_go;
  logic [W-1:0] wai_mask, wait_in;
  logic bus_gnt, wait_out, stall;

  int n_tests = 0;
  int n_fail  = 0;
  logic [2:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  bus_wait_seq #(.WAIT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .restart(restart), .bus_req(bus_req),
    .two_cyc_first(two_cyc_first), .wai_go(wai_go), .wai_mask(wai_mask),
    .wait_in(wait_in), .bus_gnt(bus_gnt), .wait_out(wait_out), .stall(stall)
  );

  // drive one cycle of inputs and queue the outputs expected in that cycle
  task automatic step(input logic rn, input logic rs, input logic rq, input logic tf,
                      input logic wg, input logic [W-1:0] mk, input logic [W-1:0] wi,
                      input logic e_gnt, input logic e_wout, input logic e_stall,
                      input string tag);
    @(negedge clk);
    rst_n = rn; restart = rs; bus_req = rq; two_cyc_first = tf;
    wai_go = wg; wai_mask = mk; wait_in = wi;
    exp_q.push_back({e_gnt, e_wout, e_stall});
    tag_q.push_back(tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_tests++;
        if ({bus_gnt, wait_out, stall} !== e) begin
          n_fail++;
          $display("FAIL %s: gnt/wout/stall actual=%b expected=%b", t,
                   {bus_gnt, wait_out, stall}, e);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; restart = 1'b0; bus_req = 1'b0; two_cyc_first = 1'b0;
    wai_go = 1'b0; wai_mask = '0; wait_in = '0;
    // R1: reset holds everything low, even with restart and request
    step(0,1,1,0,1,8'hFF,8'hFF, 0,0,0, "R1 reset with restart");
    step(0,0,1,0,0,8'h00,8'h00, 0,0,0, "R1 reset with req");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R5 idle, no wait_out");
    // R2 / R4: plain request
    step(1,0,1,0,0,8'h00,8'h00, 0,0,0, "R2 req first cycle");
    step(1,0,1,0,0,8'h00,8'h00, 1,0,1, "R2 grant rises");
    step(1,0,1,0,0,8'h00,8'h00, 1,0,1, "R4 grant held");
    step(1,0,0,0,0,8'h00,8'h00, 1,0,1, "R4 last granted cycle");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R4 grant released");
    // R3: request during first cycle of two-cycle instruction
    step(1,0,1,1,0,8'h00,8'h00, 0,0,0, "R3 req in first cycle");
    step(1,0,1,0,0,8'h00,8'h00, 0,0,0, "R3 grant deferred");
    step(1,0,1,0,0,8'h00,8'h00, 1,0,1, "R3 grant after delay");
    step(1,0,0,0,0,8'h00,8'h00, 1,0,1, "R4 held to edge");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R4 released");
    // R6 / R7: wait true, mask changes ignored, ends on foreign bit
    step(1,0,0,0,1,8'h06,8'h04, 0,1,0, "R5 wai strobe cycle");
    step(1,0,0,0,0,8'h00,8'h04, 1,1,1, "R6 first wait cycle");
    step(1,0,0,0,0,8'h00,8'h02, 1,1,1, "R7 repeat via stored mask");
    step(1,0,0,0,0,8'hFF,8'h01, 1,1,1, "R7 still waiting this cycle");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R7 wait ended");
    // R8: condition false
    step(1,0,0,0,1,8'h07,8'h08, 0,1,0, "R8 wai, condition false");
    step(1,0,0,0,0,8'h07,8'h08, 0,0,0, "R8 no wait cycle");
    // R6 with group of bits and request overlapping
    step(1,0,0,0,1,8'hF0,8'h30, 0,1,0, "R6 group mask strobe");
    step(1,0,1,0,0,8'h00,8'h00, 1,1,1, "R6 wait cycle, req arrives");
    step(1,0,1,0,0,8'h00,8'h00, 1,0,1, "R4 req holds grant after wait");
    step(1,0,0,0,0,8'h00,8'h00, 1,0,1, "R4 last granted");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R4 released after wait");
    // R9: restart
    step(1,1,0,0,0,8'h00,8'h00, 1,0,0, "R9 restart grant");
    step(1,1,1,0,0,8'h00,8'h00, 1,0,0, "R9 restart with req");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R9 grant falls with restart");
    step(1,0,0,0,1,8'h01,8'h01, 0,1,0, "R9 wai before restart");
    step(1,1,0,0,0,8'h00,8'h01, 1,1,1, "R9 restart in wait cycle");
    step(1,0,0,0,0,8'h01,8'h01, 0,0,0, "R9 wait cleared by restart");
    step(1,0,0,0,0,8'h00,8'h00, 0,0,0, "R5 idle again");
    @(negedge clk);
    @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule